// File: doc/BRIEF.md
# Dual-Port Memory with Pin Register Overlay

The block is a two-port, 16-bit synchronous memory. A left and a right port each have an active-low chip select, a read/write select (high reads, low writes), an active-low output enable and two active-low byte-lane strobes. Both ports share one array. They can read and write any word independently, with a one-cycle read latency.

An active-low overlay enable lets the memory stand in for spare processor pins. While the enable is low, the two lowest word addresses no longer reach the array. Slot 0 becomes a read-only view of two external binary inputs, which pass through a two-stage synchronizer. Slot 1 becomes a five-bit register that either port can read and write. Each set bit of that register pulls one open-drain output to ground. While the enable is high, both slots are ordinary memory words and all five open-drain outputs are released.

Access to the overlaid slots is qualified by the lower byte strobe only. The upper strobe does not matter there. Either processor can therefore poll switches and switch loads through its normal memory cycle.

Top module: `dpram_overlay`

## Requirements
- R1: With ovl_en_n low, a qualified read of word 0 returns the two synchronized input pins on rdata bits 1:0, one clock after the read cycle. Bits 15:2 read as zero. A pin change reaches the read value after two clock edges of synchronization.
- R2: With ovl_en_n low, a write to word 0 from either port changes nothing. The memory word at address 0 keeps its previous content, which a later read with ovl_en_n high shows.
- R3: With ovl_en_n high, words 0 and 1 are read and written exactly like every other memory word.
- R4: With ovl_en_n low, a qualified write to word 1 loads wdata bits 4:0 into the five-bit drive register and ignores bits 15:5. If both ports write it in the same cycle, the left port's value is kept.
- R5: With ovl_en_n low, a qualified read of word 1 returns the drive register on rdata bits 4:0 one clock later, with bits 15:5 zero.
- R6: pull_low[i] is 1 (output pulled to ground) exactly when drive register bit i is 1 and ovl_en_n is low. Otherwise it is 0 (released). The register keeps its value while the overlay is off.
- R7: A register access needs ce_n low and lb_n low, and ub_n has no effect. A read also needs we_n high and oe_n low, and a write needs we_n low. An unqualified access changes no register, and a read cycle that is not qualified returns zero.
- R8: Reset (rst_n low) clears the drive register, both rdata outputs and the synchronizer. It releases all pull_low outputs.
- R9: A memory write (ce_n low, we_n low) stores the upper byte when ub_n is low and the lower byte when lb_n is low. A memory read (ce_n low, we_n high, oe_n low) returns data one clock later, with any byte whose strobe is high read as zero. A clock with no read returns zero.
- R10: When both ports write the same memory byte in one cycle, the left port's data is stored. A read of a word that the other port writes in the same cycle returns the old content.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ovl_en_n | input | 1 | Active-low register overlay enable |
| sense_in | input | 2 | External binary inputs (asynchronous) |
| pull_low | output | 5 | Open-drain pull-down enables, 1 = pulled to ground |
| l_ce_n | input | 1 | Left chip enable, active low |
| l_we_n | input | 1 | Left read/write select, low = write |
| l_oe_n | input | 1 | Left output enable, active low |
| l_ub_n | input | 1 | Left upper byte strobe, active low |
| l_lb_n | input | 1 | Left lower byte strobe, active low |
| l_addr | input | 8 | Left word address |
| l_wdata | input | 16 | Left write data |
| l_rdata | output | 16 | Left read data, one clock after the read |
| r_ce_n | input | 1 | Right chip enable, active low |
| r_we_n | input | 1 | Right read/write select, low = write |
| r_oe_n | input | 1 | Right output enable, active low |
| r_ub_n | input | 1 | Right upper byte strobe, active low |
| r_lb_n | input | 1 | Right lower byte strobe, active low |
| r_addr | input | 8 | Right word address |
| r_wdata | input | 16 | Right write data |
| r_rdata | output | 16 | Right read data, one clock after the read |

## Verification
Two pairs of functions can fall in the same clock. In the first, both ports write the drive register together, so the left port's value must win. In the second, one port reads a word, or the register, while the other port writes it, so the read must return the previous content. Directed sequences set up both collisions on purpose. A long random phase then confines both ports to the lowest eight words and toggles the overlay enable, so collisions on the overlaid slots and on plain memory recur often. A behavioural model in the bench predicts every rdata word and the pull-down vector. It applies right-port writes before left-port writes and captures reads before any write, and the bench compares its prediction with the outputs on every clock.

// File: rtl/dpram_overlay_pkg.sv
package dpram_overlay_pkg;

    // Word slots taken over by the overlay (behaviour depends on these)
    localparam int unsigned SENSE_SLOT = 0;
    localparam int unsigned DRIVE_SLOT = 1;
    localparam int unsigned NUM_LANES  = 2;

    // Decoded intent of one port for one cycle
    typedef struct packed {
        logic [NUM_LANES-1:0] mem_rbe;   // memory read byte lanes
        logic [NUM_LANES-1:0] mem_wbe;   // memory write byte lanes
        logic                 rd_sense;  // register read of slot 0
        logic                 rd_drive;  // register read of slot 1
        logic                 wr_drive;  // register write of slot 1
    } port_acc_t;

endpackage

// File: rtl/ovl_port_decode.sv
module ovl_port_decode
    import dpram_overlay_pkg::*;
#(
    parameter int unsigned ADDR_W = 8
) (
    input  logic              ovl_en_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic              ub_n,
    input  logic              lb_n,
    input  logic [ADDR_W-1:0] addr,
    output port_acc_t         acc
);

    logic rd_cyc;
    logic wr_cyc;
    logic hit_sense;
    logic hit_drive;

    always_comb begin
        rd_cyc    = !ce_n && we_n && !oe_n;
        wr_cyc    = !ce_n && !we_n;
        hit_sense = !ovl_en_n && (addr == ADDR_W'(SENSE_SLOT));
        hit_drive = !ovl_en_n && (addr == ADDR_W'(DRIVE_SLOT));

        acc = '0;
        if (hit_sense || hit_drive) begin
            // Overlay: only the lower strobe qualifies, upper ignored
            if (!lb_n) begin
                acc.rd_sense = rd_cyc && hit_sense;
                acc.rd_drive = rd_cyc && hit_drive;
                acc.wr_drive = wr_cyc && hit_drive;
            end
        end else begin
            acc.mem_rbe = rd_cyc ? {!ub_n, !lb_n} : '0;
            acc.mem_wbe = wr_cyc ? {!ub_n, !lb_n} : '0;
        end
    end

endmodule

// File: rtl/ovl_in_sync.sv
module ovl_in_sync #(
    parameter int unsigned WIDTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    typedef struct packed {
        logic [WIDTH-1:0] meta;
        logic [WIDTH-1:0] stable;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.meta   = async_in;
        st_d.stable = st_q.meta;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sync_out = st_q.stable;

endmodule

// File: rtl/ovl_mem_bank.sv
module ovl_mem_bank
    import dpram_overlay_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    l_addr,
    input  logic [NUM_LANES-1:0] l_rbe,
    input  logic [NUM_LANES-1:0] l_wbe,
    input  logic [DATA_W-1:0]    l_wdata,
    output logic [DATA_W-1:0]    l_rdata,
    input  logic [ADDR_W-1:0]    r_addr,
    input  logic [NUM_LANES-1:0] r_rbe,
    input  logic [NUM_LANES-1:0] r_wbe,
    input  logic [DATA_W-1:0]    r_wdata,
    output logic [DATA_W-1:0]    r_rdata
);

    localparam int unsigned DEPTH  = 1 << ADDR_W;
    localparam int unsigned LANE_W = DATA_W / NUM_LANES;

    typedef struct packed {
        logic [DATA_W-1:0] l_rd;
        logic [DATA_W-1:0] r_rd;
    } rd_st_t;

    logic [DATA_W-1:0] mem [DEPTH];
    rd_st_t            st_d, st_q;

    // Read-before-write: read data comes from the array before this edge
    always_comb begin
        st_d = '0;
        for (int k = 0; k < NUM_LANES; k++) begin
            if (l_rbe[k]) st_d.l_rd[k*LANE_W +: LANE_W] = mem[l_addr][k*LANE_W +: LANE_W];
            if (r_rbe[k]) st_d.r_rd[k*LANE_W +: LANE_W] = mem[r_addr][k*LANE_W +: LANE_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // Right lanes first, left lanes last: left wins on a shared byte
    always_ff @(posedge clk) begin
        for (int k = 0; k < NUM_LANES; k++) begin
            if (r_wbe[k]) mem[r_addr][k*LANE_W +: LANE_W] <= r_wdata[k*LANE_W +: LANE_W];
            if (l_wbe[k]) mem[l_addr][k*LANE_W +: LANE_W] <= l_wdata[k*LANE_W +: LANE_W];
        end
    end

    assign l_rdata = st_q.l_rd;
    assign r_rdata = st_q.r_rd;

    // R9: a cycle without any read lane yields zero next cycle
    a_r9_idle_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (l_rbe == '0) |=> (l_rdata == '0));

endmodule

// File: rtl/ovl_regs.sv
module ovl_regs
    import dpram_overlay_pkg::*;
#(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned IN_W   = 2,
    parameter int unsigned OUT_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ovl_en_n,
    input  port_acc_t         l_acc,
    input  port_acc_t         r_acc,
    input  logic [OUT_W-1:0]  l_wbits,
    input  logic [OUT_W-1:0]  r_wbits,
    input  logic [IN_W-1:0]   sense_sync,
    output logic [OUT_W-1:0]  drive_q,
    output logic [DATA_W-1:0] l_rdata,
    output logic              l_sel,
    output logic [DATA_W-1:0] r_rdata,
    output logic              r_sel,
    output logic [OUT_W-1:0]  pull_low
);

    typedef struct packed {
        logic [OUT_W-1:0]  drive;
        logic [DATA_W-1:0] l_rd;
        logic              l_sel;
        logic [DATA_W-1:0] r_rd;
        logic              r_sel;
    } reg_st_t;

    reg_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // Right first, left last: left port wins a same-cycle write
        if (r_acc.wr_drive) st_d.drive = r_wbits;
        if (l_acc.wr_drive) st_d.drive = l_wbits;

        st_d.l_rd  = '0;
        st_d.r_rd  = '0;
        st_d.l_sel = l_acc.rd_sense || l_acc.rd_drive;
        st_d.r_sel = r_acc.rd_sense || r_acc.rd_drive;
        if (l_acc.rd_sense) st_d.l_rd = DATA_W'(sense_sync);
        if (l_acc.rd_drive) st_d.l_rd = DATA_W'(st_q.drive);
        if (r_acc.rd_sense) st_d.r_rd = DATA_W'(sense_sync);
        if (r_acc.rd_drive) st_d.r_rd = DATA_W'(st_q.drive);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign drive_q  = st_q.drive;
    assign l_rdata  = st_q.l_rd;
    assign l_sel    = st_q.l_sel;
    assign r_rdata  = st_q.r_rd;
    assign r_sel    = st_q.r_sel;
    assign pull_low = ovl_en_n ? '0 : st_q.drive;

    // R6: the drive register only moves on a qualified write
    a_r6_drive_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(l_acc.wr_drive || r_acc.wr_drive) |=> $stable(drive_q));

    // R4: left port's data wins a same-cycle double write
    a_r4_left_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (l_acc.wr_drive && r_acc.wr_drive) |=> (drive_q == $past(l_wbits)));

endmodule

// File: rtl/dpram_overlay.sv
module dpram_overlay
    import dpram_overlay_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 16,
    parameter int unsigned IN_W   = 2,
    parameter int unsigned OUT_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ovl_en_n,
    input  logic [IN_W-1:0]   sense_in,
    output logic [OUT_W-1:0]  pull_low,
    input  logic              l_ce_n,
    input  logic              l_we_n,
    input  logic              l_oe_n,
    input  logic              l_ub_n,
    input  logic              l_lb_n,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [DATA_W-1:0] l_wdata,
    output logic [DATA_W-1:0] l_rdata,
    input  logic              r_ce_n,
    input  logic              r_we_n,
    input  logic              r_oe_n,
    input  logic              r_ub_n,
    input  logic              r_lb_n,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic [DATA_W-1:0] r_wdata,
    output logic [DATA_W-1:0] r_rdata
);

    localparam int unsigned NPORT = 2;

    logic [NPORT-1:0]  p_ce_n, p_we_n, p_oe_n, p_ub_n, p_lb_n;
    logic [ADDR_W-1:0] p_addr [NPORT];
    port_acc_t         acc    [NPORT];

    logic [IN_W-1:0]   sense_sync;
    logic [OUT_W-1:0]  drive_q;
    logic [DATA_W-1:0] mem_l_rd, mem_r_rd, reg_l_rd, reg_r_rd;
    logic              reg_l_sel, reg_r_sel;

    assign p_ce_n    = {r_ce_n, l_ce_n};
    assign p_we_n    = {r_we_n, l_we_n};
    assign p_oe_n    = {r_oe_n, l_oe_n};
    assign p_ub_n    = {r_ub_n, l_ub_n};
    assign p_lb_n    = {r_lb_n, l_lb_n};
    assign p_addr[0] = l_addr;
    assign p_addr[1] = r_addr;

    for (genvar p = 0; p < NPORT; p++) begin : g_dec
        ovl_port_decode #(.ADDR_W(ADDR_W)) u_dec (
            .ovl_en_n (ovl_en_n),
            .ce_n     (p_ce_n[p]),
            .we_n     (p_we_n[p]),
            .oe_n     (p_oe_n[p]),
            .ub_n     (p_ub_n[p]),
            .lb_n     (p_lb_n[p]),
            .addr     (p_addr[p]),
            .acc      (acc[p])
        );
    end

    ovl_in_sync #(.WIDTH(IN_W)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (sense_in),
        .sync_out (sense_sync)
    );

    ovl_mem_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .l_addr  (l_addr),
        .l_rbe   (acc[0].mem_rbe),
        .l_wbe   (acc[0].mem_wbe),
        .l_wdata (l_wdata),
        .l_rdata (mem_l_rd),
        .r_addr  (r_addr),
        .r_rbe   (acc[1].mem_rbe),
        .r_wbe   (acc[1].mem_wbe),
        .r_wdata (r_wdata),
        .r_rdata (mem_r_rd)
    );

    ovl_regs #(.DATA_W(DATA_W), .IN_W(IN_W), .OUT_W(OUT_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .ovl_en_n   (ovl_en_n),
        .l_acc      (acc[0]),
        .r_acc      (acc[1]),
        .l_wbits    (l_wdata[OUT_W-1:0]),
        .r_wbits    (r_wdata[OUT_W-1:0]),
        .sense_sync (sense_sync),
        .drive_q    (drive_q),
        .l_rdata    (reg_l_rd),
        .l_sel      (reg_l_sel),
        .r_rdata    (reg_r_rd),
        .r_sel      (reg_r_sel),
        .pull_low   (pull_low)
    );

    assign l_rdata = reg_l_sel ? reg_l_rd : mem_l_rd;
    assign r_rdata = reg_r_sel ? reg_r_rd : mem_r_rd;

    // R1: slot 0 read returns the synchronized pins, upper bits zero
    a_r1_sense_read: assert property (@(posedge clk) disable iff (!rst_n)
        acc[0].rd_sense |=> (l_rdata == DATA_W'($past(sense_sync))));

    // R5: slot 1 read returns the drive register
    a_r5_drive_read: assert property (@(posedge clk) disable iff (!rst_n)
        acc[1].rd_drive |=> (r_rdata == DATA_W'($past(drive_q))));

    // R2: an overlaid write to slot 0 never reaches the array
    a_r2_sense_wr_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (!ovl_en_n && !l_ce_n && !l_we_n && l_addr == ADDR_W'(SENSE_SLOT))
            |-> (acc[0].mem_wbe == '0 && !acc[0].wr_drive));

    // R7: with the lower strobe high, overlaid slots see no access at all
    a_r7_lb_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (!ovl_en_n && r_lb_n && r_addr < ADDR_W'(2))
            |-> (acc[1] == '0));

endmodule

// File: tb/dpram_overlay_tb.sv
module dpram_overlay_tb;

    localparam int AW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ovl_en_n = 1'b1;
    logic [1:0] sense_in = '0;
    logic [4:0] pull_low;

    logic        ce_n [2];
    logic        we_n [2];
    logic        oe_n [2];
    logic        ub_n [2];
    logic        lb_n [2];
    logic [7:0]  addr [2];
    logic [15:0] wdata [2];
    logic [15:0] rdata [2];

    int total = 0;
    int bad = 0;

    // behavioural reference state
    logic [15:0] mem_m [256];
    logic [4:0]  drv_m = '0;
    logic [1:0]  s1_m = '0, s2_m = '0;
    logic [15:0] exp_rd [2];
    string       exp_tag [2];
    string       force_tag = "";

    always #10 clk = ~clk;

    dpram_overlay u_dut (
        .clk(clk), .rst_n(rst_n), .ovl_en_n(ovl_en_n), .sense_in(sense_in),
        .pull_low(pull_low),
        .l_ce_n(ce_n[0]), .l_we_n(we_n[0]), .l_oe_n(oe_n[0]), .l_ub_n(ub_n[0]),
        .l_lb_n(lb_n[0]), .l_addr(addr[0]), .l_wdata(wdata[0]), .l_rdata(rdata[0]),
        .r_ce_n(ce_n[1]), .r_we_n(we_n[1]), .r_oe_n(oe_n[1]), .r_ub_n(ub_n[1]),
        .r_lb_n(lb_n[1]), .r_addr(addr[1]), .r_wdata(wdata[1]), .r_rdata(rdata[1])
    );

    task automatic check16(string tag, string what, logic [15:0] act, logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h t=%0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic idle(int p);
        ce_n[p] = 1; we_n[p] = 1; oe_n[p] = 1; ub_n[p] = 1; lb_n[p] = 1;
        addr[p] = '0; wdata[p] = '0;
    endtask

    task automatic rd(int p, int a, bit ub = 0, bit lb = 0, bit oe = 0);
        ce_n[p] = 0; we_n[p] = 1; oe_n[p] = oe; ub_n[p] = ub; lb_n[p] = lb;
        addr[p] = 8'(a); wdata[p] = '0;
    endtask

    task automatic wr(int p, int a, logic [15:0] d, bit ub = 0, bit lb = 0);
        ce_n[p] = 0; we_n[p] = 0; oe_n[p] = 1; ub_n[p] = ub; lb_n[p] = lb;
        addr[p] = 8'(a); wdata[p] = d;
    endtask

    // Predict the outputs after the coming edge and update model state
    task automatic step_model();
        logic [4:0] drv_next;
        drv_next = drv_m;
        for (int p = 0; p < 2; p++) begin
            bit r, w, ovl;
            r   = !ce_n[p] && we_n[p] && !oe_n[p];
            w   = !ce_n[p] && !we_n[p];
            ovl = !ovl_en_n && addr[p] < 2;
            exp_rd[p] = '0;
            exp_tag[p] = "R9";
            if (ovl) begin
                exp_tag[p] = "R7";
                if (!lb_n[p] && r) begin
                    exp_rd[p]  = (addr[p] == 0) ? {14'd0, s2_m} : {11'd0, drv_m};
                    exp_tag[p] = (addr[p] == 0) ? "R1" : "R5";
                end
            end else if (r) begin
                if (!ub_n[p]) exp_rd[p][15:8] = mem_m[addr[p]][15:8];
                if (!lb_n[p]) exp_rd[p][7:0]  = mem_m[addr[p]][7:0];
                exp_tag[p] = (addr[p] < 2) ? "R3" : "R9";
            end
            if (force_tag != "") exp_tag[p] = force_tag;
        end
        for (int p = 1; p >= 0; p--) begin
            if (!ce_n[p] && !we_n[p]) begin
                if (!ovl_en_n && addr[p] < 2) begin
                    if (addr[p] == 1 && !lb_n[p]) drv_next = wdata[p][4:0];
                end else begin
                    if (!ub_n[p]) mem_m[addr[p]][15:8] = wdata[p][15:8];
                    if (!lb_n[p]) mem_m[addr[p]][7:0]  = wdata[p][7:0];
                end
            end
        end
        drv_m = drv_next;
        s2_m = s1_m;
        s1_m = sense_in;
    endtask

    task automatic compare();
        check16(exp_tag[0], "left rdata", rdata[0], exp_rd[0]);
        check16(exp_tag[1], "right rdata", rdata[1], exp_rd[1]);
        check16("R6", "pull_low", {11'd0, pull_low}, ovl_en_n ? 16'd0 : {11'd0, drv_m});
    endtask

    task automatic tick();
        step_model();
        @(negedge clk);
        compare();
    endtask

    task automatic do_reset();
        rst_n = 0;
        idle(0); idle(1);
        drv_m = '0; s1_m = '0; s2_m = '0;
        exp_rd[0] = '0; exp_rd[1] = '0;
        repeat (2) @(negedge clk);
        rst_n = 1;
        // R8: cleared state visible straight after reset
        check16("R8", "left rdata after reset", rdata[0], 16'd0);
        check16("R8", "right rdata after reset", rdata[1], 16'd0);
        check16("R8", "pull_low after reset", {11'd0, pull_low}, 16'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        idle(0); idle(1);
        @(negedge clk);
        do_reset();

        // R3/R9: fill low words with overlay off, byte-lane writes
        ovl_en_n = 1;
        for (int a = 0; a < 8; a++) begin
            wr(0, a, 16'h1100 + 16'(a * 16'h0101)); idle(1); tick();
        end
        wr(1, 3, 16'hAB00, 0, 1); idle(0); tick();           // R9 upper byte only
        rd(0, 3); rd(1, 0); tick();                          // R9 and R3 reads
        rd(0, 3, 1, 0); rd(1, 1, 0, 1); tick();              // R9 lane masking
        idle(0); idle(1); tick();                            // R9 idle zero

        // R4/R5/R6: overlay on, drive register write/read
        ovl_en_n = 0;
        wr(0, 1, 16'hFFF5); idle(1); tick();
        rd(1, 1); idle(0); tick();
        idle(1); tick();
        // R4 same-cycle double write: left must win
        force_tag = "R4";
        wr(0, 1, 16'h000A); wr(1, 1, 16'h0013); tick();
        rd(0, 1); idle(1); tick();
        force_tag = "";
        // R7: ub only, upper strobe ignored, oe high read
        wr(1, 1, 16'h001F, 0, 1); idle(0); tick();
        wr(1, 1, 16'h0011, 1, 0); tick();
        rd(0, 1, 0, 0, 1); rd(1, 1, 1, 0); tick();
        rd(0, 1, 0, 1); idle(1); tick();
        idle(0); tick();

        // R1: sense pins through the synchronizer
        sense_in = 2'b10; idle(0); idle(1);
        rd(0, 0); rd(1, 0); tick();
        rd(0, 0); tick();
        rd(0, 0); rd(1, 0, 1, 0); tick();
        sense_in = 2'b01; tick(); tick(); tick();

        // R2: write to slot 0 ignored, memory keeps old word
        wr(0, 0, 16'hDEAD); wr(1, 0, 16'hBEEF); tick();
        idle(0); idle(1); ovl_en_n = 1; tick();
        force_tag = "R2";
        rd(0, 0); tick();
        idle(0); tick();
        force_tag = "";
        // R6: register kept while released, reappears on re-enable
        ovl_en_n = 0; tick();

        // R10: read-vs-write and write-vs-write on plain memory
        force_tag = "R10";
        rd(0, 5); wr(1, 5, 16'h5A5A); tick();
        wr(0, 6, 16'h1234); wr(1, 6, 16'h9876); tick();
        rd(0, 5); rd(1, 6); tick();
        idle(0); idle(1); tick();
        force_tag = "";

        // R8: mid-run reset clears the drive register
        @(negedge clk);
        do_reset();
        rd(0, 1); tick();
        idle(0); tick();

        // Random concurrent traffic over the low words
        for (int n = 0; n < 4000; n++) begin
            if ($urandom_range(0, 7) == 0) ovl_en_n = ~ovl_en_n;
            sense_in = 2'($urandom);
            for (int p = 0; p < 2; p++) begin
                int k;
                k = $urandom_range(0, 3);
                ce_n[p] = (k == 0);
                we_n[p] = $urandom_range(0, 1) == 1;
                oe_n[p] = $urandom_range(0, 4) == 0;
                ub_n[p] = $urandom_range(0, 3) == 0;
                lb_n[p] = $urandom_range(0, 3) == 0;
                addr[p] = 8'($urandom_range(0, 7));
                wdata[p] = 16'($urandom);
            end
            tick();
        end

        idle(0); idle(1); tick();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule